// File: doc/BRIEF.md
# Repetitive Transient Peak Finder

This block measures the peak height of a transient that repeats. It does this with an external DAC that sets a threshold and an external comparator that compares the transient with that threshold. The comparator output is high while the signal is strictly above the threshold. The block writes each trial threshold to the DAC and then waits a programmable settling time. After that it opens an observation window that spans a set number of event periods. A sticky capture flag records whether the comparator went high at any moment in the window, so a one-cycle spike still counts. Each trial uses fresh repetitions of the event.

The 8-bit code is built most significant bit first. Each trial sets the next lower bit. The bit stays set if an exceedance was caught and is cleared if none was. When the least significant trial ends, the final code is reported with a one-cycle completion pulse. The result is the largest code that the signal still exceeds, so a peak of height A (A ≥ 1) yields A−1.

An optional approach-from-below mode handles a comparator with fixed hysteresis. In this mode, code 0 is written and allowed to settle before every trial code, so the comparator always meets the threshold from the same side.

Top module: `peak_seek`

## Requirements
- R1: After reset, dac_code, dac_wr, busy, done and peak_code are all 0.
- R2: A start pulse while idle raises busy in the next cycle. In that same cycle dac_wr is high for exactly one cycle, and dac_code is 0x80 (only bit 7 set), or 0 when approach_low was high at start.
- R3: After each DAC write, the block waits settle_len+1 cycles, counting the cycle in which dac_wr is high, before it observes. Comparator activity during that wait has no effect on the result.
- R4: A trial counts as an exceedance if cmp_in is high on any single sampled cycle of its observation window.
- R5: The window opens when settling ends. It closes on the window_len-th event_tick pulse, and that closing cycle's cmp_in is included. A window_len of 0 acts as 1.
- R6: When a window closes, the bit under test is kept on an exceedance and cleared otherwise. If a lower bit remains, it is set and written in the next cycle with dac_wr high. dac_code never changes without dac_wr.
- R7: After the bit 0 trial, done is high for one cycle and peak_code shows the final code. peak_code then holds until the next completion. For a peak of height A it reads A−1 (0 if A is 0, 255 if A exceeds 255).
- R8: A start pulse while busy is ignored; the search carries on unchanged.
- R9: With approach_low high at start, every trial first writes code 0 and waits settle_len+1 cycles, then writes the trial code and waits again before observing.
- R10: busy falls in the same cycle that done rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a search when idle |
| approach_low | input | 1 | Sampled at start: write code 0 before every trial |
| settle_len | input | 16 | Settling wait after each DAC write, in cycles minus one |
| window_len | input | 8 | Event ticks per observation window (0 acts as 1) |
| event_tick | input | 1 | One-cycle pulse once per event period |
| cmp_in | input | 1 | Comparator output, high while signal > threshold |
| dac_code | output | 8 | Threshold code for the DAC |
| dac_wr | output | 1 | One-cycle write strobe for dac_code |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| peak_code | output | 8 | Final code from the last search |

## Verification
The assertions check on every cycle that a launch from idle produces a DAC write, that writes occur only while busy, and that dac_code never moves without its strobe. They also check that done is a single-cycle pulse that coincides with idle, and that peak_code changes only on completion. Other properties need stimulus that only the bench's scenarios provide. These are the settle timing, glitches ignored during settling, sticky capture of one-cycle spikes, window closure on the Nth tick when events are sparse, the approach-from-below write order, the ignored restart, and the A−1 result.

// File: rtl/peak_seek.sv
module peak_seek #(
  parameter int CODE_W   = 8,
  parameter int SETTLE_W = 16,
  parameter int WIN_W    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                approach_low,
  input  logic [SETTLE_W-1:0] settle_len,
  input  logic [WIN_W-1:0]    window_len,
  input  logic                event_tick,
  input  logic                cmp_in,
  output logic [CODE_W-1:0]   dac_code,
  output logic                dac_wr,
  output logic                busy,
  output logic                done,
  output logic [CODE_W-1:0]   peak_code
);

  localparam logic [CODE_W-1:0] TOP_BIT = {1'b1, {(CODE_W-1){1'b0}}};
  localparam logic [WIN_W-1:0]  WIN_ONE = {{(WIN_W-1){1'b0}}, 1'b1};

  typedef enum logic [1:0] {IDLE, REZERO, SETTLE, WATCH} phase_t;

  phase_t              phase;
  logic [CODE_W-1:0]   trial;
  logic [CODE_W-1:0]   probe;
  logic [SETTLE_W-1:0] wait_cnt;
  logic [WIN_W-1:0]    ticks;
  logic                caught;
  logic                low_mode;

  logic [WIN_W-1:0]  win_need;
  logic              seen;
  logic              closing;
  logic              settled;
  logic [CODE_W-1:0] kept;
  logic [CODE_W-1:0] next_trial;

  assign win_need   = (window_len == '0) ? WIN_ONE : window_len;
  assign seen       = caught | cmp_in;
  assign closing    = event_tick && (ticks == win_need - WIN_ONE);
  assign settled    = (wait_cnt == settle_len);
  assign kept       = seen ? trial : (trial & ~probe);
  assign next_trial = kept | (probe >> 1);
  assign busy       = (phase != IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= IDLE;
      trial     <= '0;
      probe     <= '0;
      wait_cnt  <= '0;
      ticks     <= '0;
      caught    <= 1'b0;
      low_mode  <= 1'b0;
      dac_code  <= '0;
      dac_wr    <= 1'b0;
      done      <= 1'b0;
      peak_code <= '0;
    end else begin
      dac_wr <= 1'b0;
      done   <= 1'b0;
      case (phase)
        IDLE: begin
          if (start) begin
            low_mode <= approach_low;
            trial    <= TOP_BIT;
            probe    <= TOP_BIT;
            wait_cnt <= '0;
            dac_wr   <= 1'b1;
            if (approach_low) begin
              dac_code <= '0;
              phase    <= REZERO;
            end else begin
              dac_code <= TOP_BIT;
              phase    <= SETTLE;
            end
          end
        end
        REZERO: begin
          if (settled) begin
            dac_code <= trial;
            dac_wr   <= 1'b1;
            wait_cnt <= '0;
            phase    <= SETTLE;
          end else begin
            wait_cnt <= wait_cnt + 1'b1;
          end
        end
        SETTLE: begin
          if (settled) begin
            caught <= 1'b0;
            ticks  <= '0;
            phase  <= WATCH;
          end else begin
            wait_cnt <= wait_cnt + 1'b1;
          end
        end
        WATCH: begin
          caught <= seen;
          if (closing) begin
            if (probe[0]) begin
              trial     <= kept;
              peak_code <= kept;
              done      <= 1'b1;
              phase     <= IDLE;
            end else begin
              trial    <= next_trial;
              probe    <= probe >> 1;
              wait_cnt <= '0;
              dac_wr   <= 1'b1;
              if (low_mode) begin
                dac_code <= '0;
                phase    <= REZERO;
              end else begin
                dac_code <= next_trial;
                phase    <= SETTLE;
              end
            end
          end else if (event_tick) begin
            ticks <= ticks + WIN_ONE;
          end
        end
        default: phase <= IDLE;
      endcase
    end
  end

endmodule

// File: rtl/peak_seek_props.sv
module peak_seek_props #(
  parameter int CODE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [CODE_W-1:0] dac_code,
  input logic              dac_wr,
  input logic              busy,
  input logic              done,
  input logic [CODE_W-1:0] peak_code
);

  p_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (dac_wr && busy));

  p_wr_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dac_wr |-> busy);

  p_code_needs_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_code != $past(dac_code)) |-> dac_wr);

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_peak_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(peak_code));

  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

bind peak_seek peak_seek_props #(.CODE_W(CODE_W)) u_props (
  .clk(clk), .rst_n(rst_n), .start(start), .dac_code(dac_code),
  .dac_wr(dac_wr), .busy(busy), .done(done), .peak_code(peak_code)
);

// File: tb/peak_seek_test.sv
`timescale 1ns/1ps
module peak_seek_test;
  localparam int PER = 8;
  localparam int OFF = 3;

  logic clk = 0, rst_n = 0, start = 0, approach_low = 0;
  logic [15:0] settle_len = 0;
  logic [7:0]  window_len = 0;
  logic event_tick = 0, cmp_in = 0;
  logic [7:0] dac_code, peak_code;
  logic dac_wr, busy, done;

  int total = 0, bad = 0, cyc = 0;
  int amp = 0, every_k = 1;
  bit glitch_mode = 0;

  // reference model state
  int ph = 0, m_code = 0, m_mask = 0, m_rem = 0, m_left = 0, m_dac = 0, m_peak = 0;
  bit m_lat = 0, m_wr = 0, m_done = 0, m_rz = 0;

  always #4 clk = ~clk;

  peak_seek uut (.clk(clk), .rst_n(rst_n), .start(start), .approach_low(approach_low),
    .settle_len(settle_len), .window_len(window_len), .event_tick(event_tick),
    .cmp_in(cmp_in), .dac_code(dac_code), .dac_wr(dac_wr), .busy(busy),
    .done(done), .peak_code(peak_code));

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference, updated on each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; m_dac = 0; m_wr = 0; m_done = 0; m_peak = 0; m_lat = 0;
    end else begin
      m_wr = 0; m_done = 0;
      if (ph == 0) begin
        if (start) begin
          m_rz = approach_low; m_code = 128; m_mask = 128; m_rem = settle_len;
          m_wr = 1; m_dac = m_rz ? 0 : 128; ph = m_rz ? 1 : 2;
        end
      end else if (ph == 1) begin
        if (m_rem == 0) begin m_dac = m_code; m_wr = 1; m_rem = settle_len; ph = 2; end
        else m_rem--;
      end else if (ph == 2) begin
        if (m_rem == 0) begin m_lat = 0; m_left = (window_len == 0) ? 1 : window_len; ph = 3; end
        else m_rem--;
      end else begin
        m_lat = m_lat | cmp_in;
        if (event_tick) begin
          m_left--;
          if (m_left == 0) begin
            if (!m_lat) m_code = m_code - m_mask;
            if (m_mask == 1) begin
              m_peak = m_code; m_done = 1; ph = 0;
            end else begin
              m_mask = m_mask / 2; m_code = m_code + m_mask;
              m_wr = 1; m_rem = settle_len;
              m_dac = m_rz ? 0 : m_code; ph = m_rz ? 1 : 2;
            end
          end
        end
      end
    end
  end

  // stimulus generator, per-cycle comparison, watchdog
  always @(negedge clk) begin
    check(int'(dac_code) == m_dac, "R6 dac_code", dac_code, m_dac);
    check(dac_wr == m_wr, "R3 dac_wr timing", dac_wr, m_wr);
    check(busy == (ph != 0), "R8 busy", busy, ph != 0);
    check(done == m_done, "R7 done", done, m_done);
    check(int'(peak_code) == m_peak, "R7 peak_code", peak_code, m_peak);
    cyc++;
    event_tick = (cyc % PER) == 0;
    if (glitch_mode) cmp_in = dac_wr;
    else cmp_in = ((cyc % PER) == OFF) && (((cyc / PER) % every_k) == 0) && (amp > int'(dac_code));
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic run(int s, int w, int a, bit low, int k, bit gl, int exp_peak, string req);
    bit got = 0;
    settle_len = 16'(s); window_len = 8'(w); amp = a; approach_low = low;
    every_k = k; glitch_mode = gl;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    check(dac_wr == 1, "R2 first write strobe", dac_wr, 1);
    check(int'(dac_code) == (low ? 0 : 128), low ? "R9 first code zero" : "R2 first code 0x80",
          dac_code, low ? 0 : 128);
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (done) begin got = 1; break; end
    end
    check(got, "R7 completion seen", got, 1);
    check(!busy, "R10 idle with done", busy, 0);
    if (exp_peak >= 0) check(int'(peak_code) == exp_peak, req, peak_code, exp_peak);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(dac_code == 0 && dac_wr == 0 && busy == 0 && done == 0 && peak_code == 0,
          "R1 reset state", {dac_code, dac_wr, busy, done}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    run(3, 2, 100, 0, 1, 0, 99,  "R4 one-cycle spike peak 100");
    run(3, 2, 0,   0, 1, 0, 0,   "R7 zero peak");
    run(3, 2, 300, 0, 1, 0, 255, "R7 saturated peak");
    run(1, 2, 1,   0, 1, 0, 0,   "R7 peak of one");
    run(2, 4, 180, 0, 3, 0, 179, "R5 sparse events, window 4");
    run(2, 2, 77,  1, 1, 0, 76,  "R9 approach from below");
    run(4, 2, 0,   0, 1, 1, 0,   "R3 glitch during settle ignored");
    run(0, 0, 50,  0, 1, 0, -1,  "R5 window zero");
    // R8: restart while busy
    settle_len = 3; window_len = 2; amp = 200; approach_low = 0; every_k = 1; glitch_mode = 0;
    @(negedge clk); start = 1; @(negedge clk); start = 0;
    repeat (40) @(negedge clk);
    start = 1; @(negedge clk); start = 0;
    check(busy == 1, "R8 busy after ignored start", busy, 1);
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (done) break;
    end
    check(int'(peak_code) == 199, "R8 result after ignored start", peak_code, 199);
    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule